// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Splitter

This block is the purely combinational front end of a simple in-order processor. It takes a ten-byte window of instruction memory read at the program counter, together with the memory's error flag. From these it produces the opcode fields, the two register specifiers, the 64-bit constant word and the address of the next sequential instruction.

Instructions are 1, 2, 9 or 10 bytes long. The length follows from two presence flags decoded from the opcode: one for a register-specifier byte and one for an eight-byte constant. A failed fetch turns the instruction into a no-op, so the rest of the pipeline sees a harmless one-byte instruction. Window byte k sits on bits [8k+7:8k] of `win`.

Top module: `insn_fetch_split`

## Requirements
- R1: `icode` is bits [7:4] of byte 0 and `ifun` is bits [3:0] of byte 0 when `mem_err` is 0.
- R2: `has_regs` is 1 exactly for these values of `icode`: 2 (move), 3 (immediate load), 4 (store), 5 (load), 6 (integer op), 0xA (push) and 0xB (pop).
- R3: `has_const` is 1 exactly for these values of `icode`: 3, 4, 5, 7 (jump) and 8 (call).
- R4: When `has_regs` is 1, `ra` is bits [15:12] and `rb` is bits [11:8] of the window. Otherwise both are 0xF.
- R5: `valp` equals `pc + 1 + has_regs + 8*has_const`, wrapping modulo 2^ADDR_W.
- R6: When `has_const` is 1, `valc` is the little-endian 64-bit word starting at byte 2 if `has_regs` is 1, and at byte 1 otherwise. When `has_const` is 0, `valc` is 0.
- R7: When `mem_err` is 1, `icode` is 1 (no-op) and `ifun` is 0 whatever the window holds. `has_regs`, `has_const`, `ra`, `rb`, `valc` and `valp` then follow from that no-op.
- R8: `insn_ok` is 0 in these cases: `icode` is above 0xB; `icode` is 6 and `ifun` is above 3; `icode` is 2 or 7 and `ifun` is above 6. It is 1 in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | ADDR_W | Address of the first window byte |
| win | input | 80 | Ten fetched bytes, byte k on bits [8k+7:8k] |
| mem_err | input | 1 | Instruction memory reports a failed read |
| icode | output | 4 | Instruction class |
| ifun | output | 4 | Function within the class |
| ra | output | 4 | First register specifier or 0xF |
| rb | output | 4 | Second register specifier or 0xF |
| valc | output | 64 | Constant word or 0 |
| valp | output | ADDR_W | Next sequential address |
| insn_ok | output | 1 | Opcode/function pair is legal |
| has_regs | output | 1 | Register byte present |
| has_const | output | 1 | Constant word present |

## Verification
A fetch error can arrive together with a window whose opcode would need both a register byte and a constant. The error must win, so the outputs must collapse to a one-byte no-op even though the bytes describe a ten-byte instruction. The bench provokes this case by asserting `mem_err` on every opcode with random trailing bytes. It judges the result against its own model: `valp` must be `pc+1`, both specifiers must be 0xF and `valc` must be zero. Address wrap is exercised as well, by placing a ten-byte instruction at the top of the address space.

// File: rtl/insn_fetch_split.sv
module insn_fetch_split #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [79:0]       win,
  input  logic              mem_err,
  output logic [3:0]        icode,
  output logic [3:0]        ifun,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [63:0]       valc,
  output logic [ADDR_W-1:0] valp,
  output logic              insn_ok,
  output logic              has_regs,
  output logic              has_const
);
  localparam logic [3:0] NOP   = 4'h1;
  localparam logic [3:0] NOREG = 4'hF;

  assign icode = mem_err ? NOP : win[7:4];
  assign ifun  = mem_err ? 4'h0 : win[3:0];

  always_comb begin
    has_regs  = 1'b0;
    has_const = 1'b0;
    unique case (icode)
      4'h2, 4'h6, 4'hA, 4'hB: has_regs = 1'b1;
      4'h3, 4'h4, 4'h5: begin
        has_regs  = 1'b1;
        has_const = 1'b1;
      end
      4'h7, 4'h8: has_const = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    insn_ok = (icode <= 4'hB);
    if (icode == 4'h6 && ifun > 4'h3) insn_ok = 1'b0;
    if ((icode == 4'h2 || icode == 4'h7) && ifun > 4'h6) insn_ok = 1'b0;
  end

  assign ra = has_regs ? win[15:12] : NOREG;
  assign rb = has_regs ? win[11:8]  : NOREG;

  assign valc = !has_const ? 64'h0 : (has_regs ? win[79:16] : win[71:8]);

  assign valp = pc + ADDR_W'(1) + ADDR_W'(has_regs)
              + (has_const ? ADDR_W'(8) : ADDR_W'(0));
endmodule

// File: rtl/insn_fetch_split_chk.sv
module insn_fetch_split_chk #(
  parameter int ADDR_W = 64
) (
  input logic [ADDR_W-1:0] pc,
  input logic [79:0]       win,
  input logic              mem_err,
  input logic [3:0]        icode,
  input logic [3:0]        ifun,
  input logic [3:0]        ra,
  input logic [3:0]        rb,
  input logic [63:0]       valc,
  input logic [ADDR_W-1:0] valp,
  input logic              insn_ok,
  input logic              has_regs,
  input logic              has_const
);
  logic [ADDR_W-1:0] step;
  assign step = valp - pc;

  always_comb begin
    if (!$isunknown({pc, win, mem_err})) begin
      assert_noreg_fill_R4: assert (has_regs || (ra == 4'hF && rb == 4'hF));
      assert_len_set_R5: assert (step == ADDR_W'(1) || step == ADDR_W'(2) ||
                                 step == ADDR_W'(9) || step == ADDR_W'(10));
      assert_const_zero_R6: assert (has_const || valc == 64'h0);
      assert_err_nop_R7: assert (!mem_err || (icode == 4'h1 && ifun == 4'h0 &&
                                              step == ADDR_W'(1)));
      assert_bad_class_R8: assert (icode <= 4'hB || !insn_ok);
      assert_regs_short_R2: assert (!has_regs || step != ADDR_W'(1));
    end
  end
endmodule

bind insn_fetch_split insn_fetch_split_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_insn_fetch_split.sv
module test_insn_fetch_split;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [63:0] pc;
  logic [79:0] win;
  logic        mem_err;
  logic [3:0]  icode, ifun, ra, rb;
  logic [63:0] valc, valp;
  logic        insn_ok, has_regs, has_const;

  insn_fetch_split i_insn_fetch_split (
    .pc(pc), .win(win), .mem_err(mem_err), .icode(icode), .ifun(ifun),
    .ra(ra), .rb(rb), .valc(valc), .valp(valp), .insn_ok(insn_ok),
    .has_regs(has_regs), .has_const(has_const));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h pc=%h win=%h err=%b", req, got, exp, pc, win, mem_err);
    end
  endtask

  task automatic compare();
    int c, f, len, off;
    bit r, k, v;
    logic [63:0] w;
    c = mem_err ? 1 : int'(win[7:4]);
    f = mem_err ? 0 : int'(win[3:0]);
    r = (c inside {2, 3, 4, 5, 6, 10, 11});
    k = (c inside {3, 4, 5, 7, 8});
    len = 1 + (r ? 1 : 0) + (k ? 8 : 0);
    off = r ? 2 : 1;
    w = '0;
    if (k) for (int b = 0; b < 8; b++) w[8*b +: 8] = win[8*(off+b) +: 8];
    v = (c <= 11) && !(c == 6 && f > 3) && !((c == 2 || c == 7) && f > 6);
    chk(icode == 4'(c), mem_err ? "R7 icode" : "R1 icode", 64'(icode), 64'(c));
    chk(ifun == 4'(f), mem_err ? "R7 ifun" : "R1 ifun", 64'(ifun), 64'(f));
    chk(has_regs == r, "R2 has_regs", 64'(has_regs), 64'(r));
    chk(has_const == k, "R3 has_const", 64'(has_const), 64'(k));
    chk(ra == (r ? win[15:12] : 4'hF), "R4 ra", 64'(ra), 64'(r ? win[15:12] : 4'hF));
    chk(rb == (r ? win[11:8] : 4'hF), "R4 rb", 64'(rb), 64'(r ? win[11:8] : 4'hF));
    chk(valp == pc + 64'(len), "R5 valp", valp, pc + 64'(len));
    chk(valc == w, "R6 valc", valc, w);
    chk(insn_ok == v, "R8 insn_ok", 64'(insn_ok), 64'(v));
  endtask

  task automatic apply(input logic [63:0] p, input logic [79:0] w, input logic e);
    @(negedge clk);
    pc = p; win = w; mem_err = e;
    @(posedge clk);
    if (!rst) compare();
  endtask

  function automatic logic [79:0] rnd_win(input int op, input int fn);
    logic [79:0] w;
    for (int b = 0; b < 10; b++) w[8*b +: 8] = 8'($urandom);
    w[7:0] = {4'(op), 4'(fn)};
    return w;
  endfunction

  initial begin
    pc = '0; win = '0; mem_err = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply(64'h0, 80'h0, 1'b0);
    apply(64'h100, 80'h0000_0000_0000_0000_f330, 1'b0);
    apply(64'h100, 80'h0001_2345_6789_abcd_4240, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFA, rnd_win(3, 0), 1'b0);
    apply(64'h200, rnd_win(6, 4), 1'b0);
    apply(64'h200, rnd_win(2, 7), 1'b0);
    apply(64'h200, rnd_win(7, 6), 1'b0);
    apply(64'h200, rnd_win(12, 0), 1'b0);
    for (int op = 0; op < 16; op++)
      for (int fn = 0; fn < 16; fn++)
        apply(64'($urandom) << 8, rnd_win(op, fn), 1'b0);
    for (int op = 0; op < 16; op++)
      apply(64'hFFFF_FFFF_FFFF_FFFF, rnd_win(op, int'($urandom_range(0, 15))), 1'b1);
    for (int i = 0; i < 200; i++)
      apply({32'($urandom), 32'($urandom)}, rnd_win(int'($urandom_range(0, 15)),
            int'($urandom_range(0, 15))), 1'($urandom_range(0, 3) == 0));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule